// File: doc/BRIEF.md
# Masked I2C Target Address Matcher

This block is the address front end of an I2C target. SCL and SDA are resynchronised into the local clock. START and STOP conditions are recognised there. The first byte after a START is collected as a seven-bit address followed by a direction bit. That address is compared with a programmable own address. A programmable mask can take any address bit out of the comparison, so one target can answer to a whole family of addresses.

When the address is accepted, the block prepares the acknowledge and raises an event flag carrying a status code. It then stretches the clock until software clears the flag. A STOP or a repeated START that arrives while the target is addressed is also reported through the flag. An interrupt request can be enabled, or software can poll the flag. Data bytes after the address, general call and the controller role lie outside this block.

Software reaches four 8-bit registers through a simple write-strobe port with a combinational read:

- offset 0: own address
- offset 1: mask
- offset 2: control and flag
- offset 3: status

Top module: `i2c_masked_target`

## Requirements
- R1: The mask register (offset 1) holds the mask in bits 7..1. Bit 0 ignores writes and reads as zero. All mask bits are zero after reset, so comparison is exact after reset.
- R2: The own-address register (offset 0) holds the address in bits 7..1. Bit 0 reads as zero. It resets to zero.
- R3: Received address bit k is compared with own-address register bit k+1, and mask register bit k+1 excludes that comparison. The address matches when every bit is either equal or masked.
- R4: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Both lines pass through a synchroniser of at least two flops. After a START the next eight rising SCL edges shift in address bits MSB first, followed by the direction bit (1 = read).
- R5: Suppose the address matches and acknowledge-enable (control bit 2) is set. On the falling SCL edge after the direction bit, the block pulls SDA low for the ninth clock and sets the flag (control bit 7). The status (offset 3) then reads 0x60 for a write or 0xA8 for a read.
- R6: On a mismatch, or with acknowledge-enable clear, SDA is never pulled low, the flag stays clear and the block ignores the bus until the next START.
- R7: `irq_o` is high exactly when the flag, interrupt-enable (control bit 0) and `gie_i` are all high.
- R8: While the flag set by an address event is pending, SCL is held low. Writing control with bit 7 set clears the flag and releases SCL. Writing bit 7 as zero leaves the flag unchanged.
- R9: A STOP or repeated START while addressed sets the flag with status 0xA0 without holding SCL. A repeated START also begins a new address phase.
- R10: While the flag is clear the status reads 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| gie_i | input | 1 | Global interrupt enable |
| reg_addr | input | 2 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |

## Verification
The bench builds the block with the default two-stage synchroniser. Five clocks between bus steps therefore cover the whole path from a pin edge to a flag change. The bench models open-drain lines, so the stretch and the acknowledge are seen on the wires themselves. Its vectors cover these mask patterns:

- no mask
- low bits masked
- only the MSB masked
- all bits masked
- bit 0 masked, with both a match and a near-miss

Together these reach both ends of the address range and both directions. Directed cases cover the repeated START, a zero written to the flag bit, the global enable and a disabled acknowledge.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef logic [ADDR_W-1:0] addr_t;

  localparam logic [7:0] CODE_WR_ACK = 8'h60;
  localparam logic [7:0] CODE_RD_ACK = 8'hA8;
  localparam logic [7:0] CODE_STOP   = 8'hA0;
  localparam logic [7:0] CODE_NONE   = 8'hF8;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_ACK, PH_ADDRESSED} phase_t;

  function automatic logic masked_hit(addr_t rx, addr_t own, addr_t msk);
    return &((rx ~^ own) | msk);
  endfunction
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  initial assert_stages_R4: assert (STAGES >= 2);
endmodule

// File: rtl/i2cm_addr_cmp.sv
module i2cm_addr_cmp
  import i2cm_pkg::*;
(
  input  addr_t rx,
  input  addr_t own,
  input  addr_t msk,
  output logic  hit
);
  logic [ADDR_W-1:0] bit_ok;

  for (genvar k = 0; k < ADDR_W; k++) begin : g_bit
    assign bit_ok[k] = (rx[k] == own[k]) | msk[k];
  end

  assign hit = &bit_ok;

  always_comb begin
    if (&msk) assert_full_mask_R3: assert (hit);
  end
endmodule

// File: rtl/i2cm_addr_fsm.sv
module i2cm_addr_fsm
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       hit,
  input  logic       ack_en,
  input  logic       flag_clr,
  output addr_t      rx_addr,
  output logic       flag,
  output logic       hold,
  output logic [7:0] code,
  output logic       sda_low
);
  phase_t            phase;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              byte_done;

  assign rx_addr   = shreg[BYTE_W-1:1];
  assign byte_done = (cnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      shreg   <= '0;
      cnt     <= '0;
      flag    <= 1'b0;
      hold    <= 1'b0;
      code    <= CODE_NONE;
      sda_low <= 1'b0;
    end else begin
      if (flag_clr) begin
        flag <= 1'b0;
        hold <= 1'b0;
      end
      if (start_ev || stop_ev) begin
        if (phase == PH_ADDRESSED) begin
          flag <= 1'b1;
          hold <= 1'b0;
          code <= CODE_STOP;
        end
        phase   <= start_ev ? PH_ADDR : PH_IDLE;
        cnt     <= '0;
        sda_low <= 1'b0;
      end else begin
        case (phase)
          PH_ADDR: begin
            if (scl_rise && !byte_done) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && byte_done) begin
              if (hit && ack_en) begin
                sda_low <= 1'b1;
                flag    <= 1'b1;
                hold    <= 1'b1;
                code    <= shreg[0] ? CODE_RD_ACK : CODE_WR_ACK;
                phase   <= PH_ACK;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              sda_low <= 1'b0;
              phase   <= PH_ADDRESSED;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_ack_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> $past(hit && ack_en));
  assert_flag_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> (code != CODE_NONE));
  assert_ack_stretched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> hold);
endmodule

// File: rtl/i2c_masked_target.sv
module i2c_masked_target
  import i2cm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       gie_i,
  input  logic [1:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_o,
  output logic       scl_low_o,
  output logic       sda_low_o
);
  localparam logic [1:0] OFS_OWN = 2'd0, OFS_MASK = 2'd1, OFS_CTRL = 2'd2;
  localparam int FLAG_BIT = 7, ACKEN_BIT = 2, IEN_BIT = 0;

  logic [1:0] pin_vec, lvl_vec, rise_vec, fall_vec;
  assign pin_vec = {sda_i, scl_i};

  for (genvar i = 0; i < 2; i++) begin : g_sync
    i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pin_vec[i]),
      .lvl(lvl_vec[i]), .rise(rise_vec[i]), .fall(fall_vec[i]));
  end

  logic start_ev, stop_ev;
  assign start_ev = fall_vec[1] & lvl_vec[0];
  assign stop_ev  = rise_vec[1] & lvl_vec[0];

  addr_t      own_q, mask_q, rx_addr;
  logic       ack_en_q, ien_q, hit, flag, hold, flag_clr;
  logic [7:0] code, status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= '0;
      mask_q   <= '0;
      ack_en_q <= 1'b0;
      ien_q    <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_OWN:  own_q  <= reg_wdata[7:1];
        OFS_MASK: mask_q <= reg_wdata[7:1];
        OFS_CTRL: begin
          ack_en_q <= reg_wdata[ACKEN_BIT];
          ien_q    <= reg_wdata[IEN_BIT];
        end
        default: ;
      endcase
    end
  end

  assign flag_clr = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[FLAG_BIT];

  i2cm_addr_cmp u_cmp (.rx(rx_addr), .own(own_q), .msk(mask_q), .hit(hit));

  i2cm_addr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(rise_vec[0]), .scl_fall(fall_vec[0]), .sda_lvl(lvl_vec[1]),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .hit(hit), .ack_en(ack_en_q), .flag_clr(flag_clr),
    .rx_addr(rx_addr), .flag(flag), .hold(hold), .code(code), .sda_low(sda_low_o));

  assign status    = flag ? code : CODE_NONE;
  assign scl_low_o = flag & hold;
  assign irq_o     = flag & ien_q & gie_i;

  always_comb begin
    case (reg_addr)
      OFS_OWN:  reg_rdata = {own_q, 1'b0};
      OFS_MASK: reg_rdata = {mask_q, 1'b0};
      OFS_CTRL: reg_rdata = {flag, 4'b0, ack_en_q, 1'b0, ien_q};
      default:  reg_rdata = status;
    endcase
  end

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag);
  assert_stretch_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low_o |-> flag);
  assert_mask_lsb_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_MASK) |-> !reg_rdata[0]);
  assert_no_stretch_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) && (status == CODE_STOP) |-> !scl_low_o);
endmodule

// File: tb/i2c_masked_target_tb.sv
module i2c_masked_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int G = 6;
  localparam int NV = 8;
  // {own[6:0], mask[6:0], rx[6:0], rw, expected_ack}
  localparam logic [22:0] VEC [NV] = '{
    {7'h50, 7'h00, 7'h50, 1'b0, 1'b1},
    {7'h50, 7'h00, 7'h51, 1'b0, 1'b0},
    {7'h50, 7'h03, 7'h53, 1'b1, 1'b1},
    {7'h50, 7'h40, 7'h10, 1'b1, 1'b1},
    {7'h50, 7'h7F, 7'h2A, 1'b0, 1'b1},
    {7'h7F, 7'h01, 7'h7E, 1'b0, 1'b1},
    {7'h7F, 7'h01, 7'h7D, 1'b0, 1'b0},
    {7'h00, 7'h00, 7'h00, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, gie = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic irq, scl_low, sda_low, scl_m = 1'b1, sda_m = 1'b1, scl_w, sda_w;
  int checks = 0, fails = 0;

  assign scl_w = scl_m & ~scl_low;
  assign sda_w = sda_m & ~sda_low;

  i2c_masked_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w), .gie_i(gie),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq), .scl_low_o(scl_low), .sda_low_o(sda_low));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(G); scl_m = 1'b1; tick(G); scl_m = 1'b0; tick(G);
  endtask

  task automatic start_cond();
    sda_m = 1'b1; tick(G); scl_m = 1'b1; tick(G); sda_m = 1'b0; tick(G); scl_m = 1'b0; tick(G);
  endtask

  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic ninth_clock(input logic exp_ack);
    sda_m = 1'b1; tick(G); scl_m = 1'b1; tick(G);
    chk("R5 ack level on SDA", {7'd0, sda_w}, {7'd0, ~exp_ack});
    scl_m = 1'b0; tick(G);
    chk("R5 SDA released after ack", {7'd0, sda_low}, 8'd0);
  endtask

  task automatic stop_cond();
    sda_m = 1'b0; tick(G); scl_m = 1'b1; tick(G); sda_m = 1'b1; tick(G);
  endtask

  function automatic logic exp_hit(input logic [6:0] own, input logic [6:0] msk, input logic [6:0] rx);
    logic ok = 1'b1;
    for (int k = 0; k < 7; k++) if (!msk[k] && (own[k] != rx[k])) ok = 1'b0;
    return ok;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic e;
    tick(3); rst_n = 1'b1; tick(2);
    rd(2'd0, d); chk("R2 own reset", d, 8'h00);
    rd(2'd1, d); chk("R1 mask reset", d, 8'h00);
    rd(2'd2, d); chk("R8 ctrl reset", d, 8'h00);
    rd(2'd3, d); chk("R10 idle status", d, 8'hF8);
    chk("R7 irq reset", {5'd0, irq, scl_low, sda_low}, 8'd0);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R1 mask bit0 reads zero", d, 8'hFE);
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 own bit0 reads zero", d, 8'hFE);
    wr(2'd1, 8'h00);

    gie = 1'b1;
    for (int v = 0; v < NV; v++) begin
      logic [6:0] own, msk, rx;
      logic rw, tbl;
      {own, msk, rx, rw, tbl} = VEC[v];
      e = exp_hit(own, msk, rx);
      chk("R3 table agrees with rule", {7'd0, e}, {7'd0, tbl});
      wr(2'd0, {own, 1'b0}); wr(2'd1, {msk, 1'b0}); wr(2'd2, 8'h05);
      start_cond();
      byte_out({rx, rw});
      tick(G);
      rd(2'd2, d); chk("R3 R4 flag after address", {7'd0, d[7]}, {7'd0, e});
      rd(2'd3, d); chk("R5 R6 R10 status", d, e ? (rw ? 8'hA8 : 8'h60) : 8'hF8);
      chk("R5 R6 SDA pull", {7'd0, sda_low}, {7'd0, e});
      chk("R8 SCL stretch", {7'd0, scl_low}, {7'd0, e});
      chk("R7 irq", {7'd0, irq}, {7'd0, e});
      if (e) begin
        tick(G);
        chk("R8 stretch persists", {7'd0, scl_w}, 8'd0);
        wr(2'd2, 8'h85); tick(G);
        chk("R8 clear releases SCL", {7'd0, scl_low}, 8'd0);
      end
      ninth_clock(e);
      stop_cond(); tick(G);
      rd(2'd2, d); chk("R9 flag on stop", {7'd0, d[7]}, {7'd0, e});
      rd(2'd3, d); chk("R9 R10 stop status", d, e ? 8'hA0 : 8'hF8);
      chk("R9 no stretch on stop", {7'd0, scl_low}, 8'd0);
      if (e) wr(2'd2, 8'h85);
    end

    wr(2'd0, {7'h3C, 1'b0}); wr(2'd1, 8'h00); wr(2'd2, 8'h05);
    start_cond(); byte_out({7'h3C, 1'b0}); tick(G);
    wr(2'd2, 8'h05); tick(G);
    rd(2'd2, d); chk("R8 zero in flag bit keeps flag", {7'd0, d[7]}, 8'd1);
    gie = 1'b0; tick(1);
    chk("R7 global enable off", {7'd0, irq}, 8'd0);
    gie = 1'b1; tick(1);
    chk("R7 global enable on", {7'd0, irq}, 8'd1);
    wr(2'd2, 8'h84); tick(1);
    chk("R7 local enable off", {7'd0, irq}, 8'd0);
    wr(2'd2, 8'h85);
    ninth_clock(1'b1);
    sda_m = 1'b1; tick(G); scl_m = 1'b1; tick(G); sda_m = 1'b0; tick(G);
    rd(2'd3, d); chk("R9 repeated start status", d, 8'hA0);
    chk("R9 repeated start no stretch", {7'd0, scl_low}, 8'd0);
    wr(2'd2, 8'h85);
    scl_m = 1'b0; tick(G);
    byte_out({7'h3C, 1'b1}); tick(G);
    rd(2'd3, d); chk("R9 R5 new address phase read", d, 8'hA8);
    wr(2'd2, 8'h85);
    ninth_clock(1'b1);
    stop_cond(); tick(G); wr(2'd2, 8'h85);

    wr(2'd2, 8'h01);
    start_cond(); byte_out({7'h3C, 1'b0}); tick(G);
    rd(2'd2, d); chk("R6 ack disabled no flag", {7'd0, d[7]}, 8'd0);
    chk("R6 ack disabled no SDA pull", {7'd0, sda_low}, 8'd0);
    ninth_clock(1'b0);
    stop_cond(); tick(G);
    rd(2'd3, d); chk("R6 R10 ignored until start", d, 8'hF8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule